// File: doc/BRIEF.md
# Page access permission evaluator

This block sits behind a page-table walker and turns the protection summary of a finished walk into a permission decision. It receives the combined user, read/write and no-execute bits of the translation, the protection key of the leaf entry, the kind of access (load, store or fetch) and the privilege of the requester. It also receives the paging control modes: write-protect, supervisor access prevention, supervisor execute prevention, two protection-key enables, and the two 32-bit key rights registers (user and supervisor).

Each clock it registers a read/write/execute permission mask, an allowed flag for the requested access, and a flag that marks a denial caused by the protection key rather than by the page bits. The result appears on the outputs one cycle after the inputs. The walker or fault logic uses these three outputs to fill a TLB entry or to raise a fault.

Top module: `page_perm_eval`

## Requirements
- R1: A user access (`user_mode`=1) to a page whose combined user bit is clear gives `perm`=0, `allowed`=0 and `pkey_fault`=0.
- R2: `perm[0]` (read) is set unless the access is a supervisor access with `smap_en`=1 to a user page.
- R3: `perm[1]` (write) needs read permission and either `pg_rw`=1, or a supervisor access with `wp_en`=0.
- R4: `perm[2]` (execute) needs `pg_nx`=0; a supervisor access with `smep_en`=1 to a user page also loses it.
- R5: A user page takes key rights from `ukey_rights` when `ukey_en`=1; a supervisor page takes them from `skey_rights` when `skey_en`=1; a disabled register reads as zero.
- R6: For key k the rights bit 2k is access-disable and bit 2k+1 is write-disable. Access-disable removes read and write; write-disable removes write only for user accesses or when `wp_en`=1; keys never remove execute.
- R7: When the key-limited mask denies the requested access, `pkey_fault`=1 (and `allowed`=0), even when the page bits alone would also deny it.
- R8: `acc_type` encodes 0 load, 1 store, 2 fetch and selects `perm` bit 0, 1 or 2; `allowed` equals that bit.
- R9: A selected rights value of zero leaves the mask untouched and never raises `pkey_fault`.
- R10: `acc_type`=3 is reserved: `allowed`=0 and `pkey_fault`=0.
- R11: Outputs are registered: they reflect the inputs of the previous clock, and reset clears all of them to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous-style reset of the output registers |
| pg_user | input | 1 | Combined user bit of the translation |
| pg_rw | input | 1 | Combined read/write bit of the translation |
| pg_nx | input | 1 | Combined no-execute bit of the translation |
| pg_key | input | KEY_BITS | Protection key of the leaf entry |
| acc_type | input | 2 | 0 load, 1 store, 2 fetch, 3 reserved |
| user_mode | input | 1 | Requester is at user privilege |
| wp_en | input | 1 | Write-protect mode for supervisor writes |
| smap_en | input | 1 | Supervisor access prevention active |
| smep_en | input | 1 | Supervisor execute prevention active |
| ukey_en | input | 1 | User key rights enable |
| skey_en | input | 1 | Supervisor key rights enable |
| ukey_rights | input | 2*2**KEY_BITS | Rights register for user pages |
| skey_rights | input | 2*2**KEY_BITS | Rights register for supervisor pages |
| perm | output | 3 | Permission mask: bit 0 read, bit 1 write, bit 2 execute |
| allowed | output | 1 | Requested access may proceed |
| pkey_fault | output | 1 | Denial is due to the protection key |

## Verification
The bench aims at the interplay of the overrides: supervisor writes to read-only pages with write-protect on and off, write-disable keys that a supervisor without write-protect ignores, and a page-bit denial that coincides with a key denial. A design that swapped the rights registers would fault user pages on supervisor rights, one that read the key bits at k instead of 2k would apply the wrong key, and one that let keys mask execute would block fetches. It also checks that a user access to a supervisor page reports a plain fault rather than a key fault, and that the reserved access type never grants.

// File: rtl/page_perm_eval.sv
module page_perm_eval #(
  parameter int KEY_BITS = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              pg_user,
  input  logic                              pg_rw,
  input  logic                              pg_nx,
  input  logic [KEY_BITS-1:0]               pg_key,
  input  logic [1:0]                        acc_type,
  input  logic                              user_mode,
  input  logic                              wp_en,
  input  logic                              smap_en,
  input  logic                              smep_en,
  input  logic                              ukey_en,
  input  logic                              skey_en,
  input  logic [2*(1<<KEY_BITS)-1:0]        ukey_rights,
  input  logic [2*(1<<KEY_BITS)-1:0]        skey_rights,
  output logic [2:0]                        perm,
  output logic                              allowed,
  output logic                              pkey_fault
);
  localparam int NKEYS    = 1 << KEY_BITS;
  localparam int RIGHTS_W = 2 * NKEYS;

  logic [RIGHTS_W-1:0] rights;
  logic [KEY_BITS:0]   ad_idx;
  logic                key_on, key_ad, key_wd, strict_w;
  logic                user_fault, base_r, base_w, base_x;
  logic [2:0]          key_mask, perm_n;
  logic                acc_ok, perm_bit, key_bit;

  assign rights = pg_user ? (ukey_en ? ukey_rights : '0)
                          : (skey_en ? skey_rights : '0);
  assign key_on = |rights;
  assign ad_idx = {pg_key, 1'b0};
  assign key_ad = rights[ad_idx];
  assign key_wd = rights[ad_idx + 1'b1];

  assign strict_w   = user_mode | wp_en;
  assign user_fault = user_mode & ~pg_user;

  assign base_r = ~(smap_en & ~user_mode & pg_user);
  assign base_w = base_r & (pg_rw | ~strict_w);
  assign base_x = ~pg_nx & (user_mode | ~(smep_en & pg_user));

  always_comb begin
    key_mask = 3'b111;
    if (key_on) begin
      if (key_ad)                   key_mask[1:0] = 2'b00;
      else if (key_wd && strict_w)  key_mask[1]   = 1'b0;
    end
  end

  assign perm_n = user_fault ? 3'b000 : ({base_x, base_w, base_r} & key_mask);

  always_comb begin
    acc_ok = 1'b1;
    case (acc_type)
      2'd0:    begin perm_bit = perm_n[0]; key_bit = key_mask[0]; end
      2'd1:    begin perm_bit = perm_n[1]; key_bit = key_mask[1]; end
      2'd2:    begin perm_bit = perm_n[2]; key_bit = key_mask[2]; end
      default: begin perm_bit = 1'b0; key_bit = 1'b1; acc_ok = 1'b0; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      perm       <= 3'b000;
      allowed    <= 1'b0;
      pkey_fault <= 1'b0;
    end else begin
      perm       <= perm_n;
      allowed    <= acc_ok & perm_bit;
      pkey_fault <= acc_ok & ~user_fault & ~key_bit;
    end
  end

  assert_user_to_sup_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (user_mode && !pg_user) |=> (perm == 3'b000 && !allowed && !pkey_fault));

  assert_write_needs_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    perm[1] |-> perm[0]);

  assert_nx_blocks_exec_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pg_nx |=> !perm[2]);

  assert_key_fault_denies_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pkey_fault |-> !allowed);

  assert_no_rights_no_fault_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ukey_en && !skey_en) |=> !pkey_fault);

  assert_reserved_type_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_type == 2'd3) |=> (!allowed && !pkey_fault));

  assert_fetch_no_key_fault_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_type == 2'd2) |=> !pkey_fault);
endmodule

// File: tb/page_perm_eval_test.sv
module page_perm_eval_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pg_user = 0, pg_rw = 0, pg_nx = 0;
  logic [3:0]  pg_key = 0;
  logic [1:0]  acc_type = 0;
  logic        user_mode = 0, wp_en = 0, smap_en = 0, smep_en = 0;
  logic        ukey_en = 0, skey_en = 0;
  logic [31:0] ukey_rights = 0, skey_rights = 0;
  logic [2:0]  perm;
  logic        allowed, pkey_fault;

  int checks = 0, fails = 0, cycles = 0;
  logic [2:0] exp_perm;
  logic       exp_allow, exp_pk;
  string      tag;

  always #10 clk = ~clk;

  page_perm_eval uut (
    .clk(clk), .rst_n(rst_n), .pg_user(pg_user), .pg_rw(pg_rw), .pg_nx(pg_nx),
    .pg_key(pg_key), .acc_type(acc_type), .user_mode(user_mode), .wp_en(wp_en),
    .smap_en(smap_en), .smep_en(smep_en), .ukey_en(ukey_en), .skey_en(skey_en),
    .ukey_rights(ukey_rights), .skey_rights(skey_rights),
    .perm(perm), .allowed(allowed), .pkey_fault(pkey_fault));

  task automatic check(string req, int act, int expv, string what);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic model();
    int rd, wr, ex, kr, kw, pk, rv, ad, wd, sel;
    int sup = (user_mode == 0);
    if (user_mode && !pg_user) begin
      exp_perm = 0; exp_allow = 0; exp_pk = 0; return;
    end
    rd = (sup && smap_en && pg_user) ? 0 : 1;
    wr = rd && (pg_rw || (sup && !wp_en));
    ex = !pg_nx && !(sup && smep_en && pg_user);
    if (pg_user) rv = ukey_en ? int'(ukey_rights) : 0;
    else         rv = skey_en ? int'(skey_rights) : 0;
    kr = 1; kw = 1;
    if (rv != 0) begin
      ad = (rv >> (pg_key * 2)) & 1;
      wd = (rv >> (pg_key * 2 + 1)) & 1;
      if (ad) begin kr = 0; kw = 0; end
      else if (wd && (!sup || wp_en)) kw = 0;
    end
    exp_perm = {1'(ex), 1'(wr && kw), 1'(rd && kr)};
    sel = acc_type;
    pk = 0;
    if (sel == 0) pk = !kr;
    if (sel == 1) pk = !kw;
    exp_pk = 1'(pk);
    exp_allow = (sel == 3) ? 1'b0 : exp_perm[sel];
  endtask

  task automatic step(string t);
    model();
    tag = t;
    @(negedge clk);
    check(tag, perm, exp_perm, "perm");
    check(tag, allowed, exp_allow, "allowed");
    check(tag, pkey_fault, exp_pk, "pkey_fault");
  endtask

  task automatic setp(bit u, bit rw, bit nx, int key, int acc, bit um);
    pg_user = u; pg_rw = rw; pg_nx = nx; pg_key = 4'(key);
    acc_type = 2'(acc); user_mode = um;
  endtask

  task automatic setm(bit wp, bit smap, bit smep, bit ue, bit se,
                      logic [31:0] ur, logic [31:0] sr);
    wp_en = wp; smap_en = smap; smep_en = smep; ukey_en = ue; skey_en = se;
    ukey_rights = ur; skey_rights = sr;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    setp(1, 1, 0, 0, 0, 1);
    @(negedge clk);
    @(negedge clk);
    check("R11", perm, 0, "reset perm");
    check("R11", allowed, 0, "reset allowed");
    check("R11", pkey_fault, 0, "reset pkey_fault");
    rst_n = 1'b1;

    setm(0, 0, 0, 0, 0, 0, 0);
    setp(1, 1, 0, 0, 1, 1); step("R8");
    setp(0, 1, 0, 0, 0, 1); step("R1");
    setm(0, 0, 0, 1, 1, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    setp(0, 0, 0, 3, 1, 1); step("R1");
    setm(0, 1, 0, 0, 0, 0, 0);
    setp(1, 1, 0, 0, 0, 0); step("R2");
    setp(1, 1, 0, 0, 0, 1); step("R2");
    setm(0, 0, 0, 0, 0, 0, 0);
    setp(0, 0, 0, 0, 1, 0); step("R3");
    setm(1, 0, 0, 0, 0, 0, 0);
    setp(0, 0, 0, 0, 1, 0); step("R3");
    setp(1, 0, 0, 0, 1, 1); step("R3");
    setm(0, 0, 1, 0, 0, 0, 0);
    setp(1, 1, 0, 0, 2, 0); step("R4");
    setp(1, 1, 0, 0, 2, 1); step("R4");
    setp(0, 1, 1, 0, 2, 0); step("R4");
    setm(1, 0, 0, 1, 0, 32'h0000_0100, 32'h0);
    setp(1, 1, 0, 4, 0, 1); step("R6");
    setp(1, 1, 0, 4, 2, 1); step("R6");
    setp(1, 1, 0, 2, 0, 1); step("R6");
    setm(0, 0, 0, 0, 1, 32'h0, 32'h0000_0080);
    setp(0, 1, 0, 3, 1, 0); step("R6");
    setm(1, 0, 0, 0, 1, 32'h0, 32'h0000_0080);
    setp(0, 1, 0, 3, 1, 0); step("R6");
    setm(0, 0, 0, 1, 0, 32'h0, 32'hFFFF_FFFF);
    setp(0, 1, 0, 5, 0, 0); step("R5");
    setm(0, 0, 0, 0, 1, 32'hFFFF_FFFF, 32'h0);
    setp(1, 1, 0, 5, 0, 1); step("R5");
    setm(0, 0, 0, 1, 1, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    setp(1, 1, 0, 5, 0, 1); step("R5");
    setm(1, 0, 0, 1, 0, 32'h0000_0002, 32'h0);
    setp(1, 0, 0, 0, 1, 1); step("R7");
    setm(0, 1, 0, 1, 1, 32'h0000_0001, 32'h0000_0001);
    setp(1, 1, 0, 0, 0, 0); step("R7");
    setm(0, 0, 0, 1, 1, 32'h0, 32'h0);
    setp(1, 1, 0, 9, 1, 1); step("R9");
    setp(1, 1, 0, 0, 3, 1); step("R10");
    setm(0, 0, 0, 1, 0, 32'h0000_0001, 32'h0);
    setp(1, 1, 0, 0, 3, 1); step("R10");

    for (int i = 0; i < 400; i++) begin
      setp($urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1),
           $urandom_range(0, 15), $urandom_range(0, 3), $urandom_range(0, 1));
      setm($urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1),
           $urandom_range(0, 1), $urandom_range(0, 1),
           ($urandom_range(0, 3) == 0) ? 32'h0 : $urandom,
           ($urandom_range(0, 3) == 0) ? 32'h0 : $urandom);
      step("R8");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule